// File: doc/BRIEF.md
# Sequence-Armed Watchdog Timer

This block resets the system when software stops servicing it. Software reaches it through a small write port that addresses two registers. The service register takes a two-byte unlock sequence. The program register holds a 3-bit period selector. After a chip reset the watchdog is off. The first complete service sequence turns it on. Every later complete sequence restarts its count. Once it is running, software has no way to turn it off.

The time base is a prescaler followed by a programmable counter. Both advance on a tick strobe inside the single system clock domain. The tick fires on every system clock, or on every second clock, depending on two mode inputs. When the selected period runs out, the block drives a reset pulse of fixed width. It then returns to its off state, exactly as after a chip reset.

Top module: `wdog_top`

## Requirements
- R1: After `rst_n` is released, `wdt_reset` is 0 and the watchdog is off. No pulse appears until a service sequence completes, however long the wait.
- R2: A write of 8'h1E to the service register (`wr_sel`=1) arms the sequence. A following service-register write of 8'hE1 turns the watchdog on and clears the prescaler and counter. Writes to the program register (`wr_sel`=0) in between do not break the arming.
- R3: Any other service-register write breaks the arming. This includes an 8'hE1 that was not preceded by 8'h1E, and any value other than 8'h1E or 8'hE1. An 8'hE1 on its own never turns the watchdog on.
- R4: The period selector `wto` is `wr_data[2:0]` of the last program-register write, captured when a service sequence completes. The pulse starts after 2^PRE_W × 2^wto ticks, counted from the clock edge that accepted the 8'hE1.
- R5: Ticks come every second clock when `half_sel`=1 or `x2_mode`=0, and on every clock otherwise. `wdt_reset` therefore rises N or 2N clocks after the 8'hE1 edge, where N is the tick count from R4.
- R6: While running, no write turns the watchdog off. A write that does not complete the sequence does not restart the count.
- R7: A complete sequence while running restarts the period from zero.
- R8: A program-register write while running leaves the current period unchanged. It takes effect at the next complete sequence.
- R9: `wdt_reset` stays high for exactly PULSE_LEN clocks (default 96).
- R10: After the pulse the watchdog is off, the arming is cleared and the program register reads as 0, as after a chip reset.
- R11: Writes made while `wdt_reset` is high are ignored. This applies to both registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low chip reset |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_sel | input | 1 | Register select: 1 = service register, 0 = program register |
| wr_data | input | 8 | Write data |
| half_sel | input | 1 | Forces the tick to every second clock |
| x2_mode | input | 1 | Double-speed mode; with `half_sel`=0 gives a tick on every clock |
| wdt_reset | output | 1 | Watchdog reset pulse, active high |

## Verification
Two situations are hard to reach from the ports. One is the pulse's interaction with later traffic: proving that writes during the pulse are ignored, and that the block afterwards really is off with a cleared period selector. The bench drives a full service sequence and a program write while the pulse is high. It then watches a quiet window longer than any period, and checks that a fresh service falls back to the shortest period. The prescaler width is reduced through its parameter so that all eight periods, in both tick rates, fit into one run. Random runs mix broken sequences and stray program writes ahead of the real service.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam logic [7:0] SEQ_ARM  = 8'h1E;
    localparam logic [7:0] SEQ_FIRE = 8'hE1;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_PULSE = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic run,
    input  logic half_rate,
    output logic tick
);
    typedef struct packed {
        logic phase;
    } tick_st_t;

    tick_st_t st_d, st_q;

    assign tick = run & (~half_rate | st_q.phase);

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.phase = 1'b0;
        end else if (run) begin
            st_d.phase = ~st_q.phase;
        end else begin
            st_d.phase = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdog_seq_det.sv
module wdog_seq_det
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output logic       service
);
    typedef struct packed {
        logic armed;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    svc_wr;

    assign svc_wr  = wr_en & wr_sel;
    assign service = svc_wr & (wr_data == SEQ_FIRE) & st_q.armed;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.armed = 1'b0;
        end else if (svc_wr) begin
            st_d.armed = (wr_data == SEQ_ARM);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
    parameter int PRE_W = 14,
    parameter int WTO_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             run,
    input  logic             tick,
    input  logic [WTO_W-1:0] wto,
    output logic             expire
);
    localparam int CNT_W = (1 << WTO_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } tb_st_t;

    tb_st_t           st_d, st_q;
    logic [CNT_W-1:0] limit;
    logic             pre_wrap;
    logic             at_limit;

    assign limit    = ~({CNT_W{1'b1}} << wto);
    assign pre_wrap = &st_q.pre;
    assign at_limit = (st_q.cnt == limit);
    assign expire   = run & tick & pre_wrap & at_limit;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else if (run && tick) begin
            st_d.pre = st_q.pre + 1'b1;
            if (pre_wrap && !at_limit) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int PRE_W     = 14,
    parameter int WTO_W     = 3,
    parameter int PULSE_LEN = 96
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       half_sel,
    input  logic       x2_mode,
    output logic       wdt_reset
);
    localparam int PCNT_W = $clog2(PULSE_LEN);

    typedef struct packed {
        wd_state_e         state;
        logic [PCNT_W-1:0] pcnt;
        logic [WTO_W-1:0]  prog;
        logic [WTO_W-1:0]  wto_act;
    } top_st_t;

    top_st_t st_d, st_q;
    wd_state_e state_q;

    logic wr_ok;
    logic service;
    logic expire;
    logic tick;
    logic run;
    logic pulse_end;
    logic flush;
    logic half_rate;

    assign state_q   = st_q.state;
    assign wr_ok     = wr_en & (st_q.state != ST_PULSE);
    assign run       = (st_q.state == ST_RUN);
    assign pulse_end = (st_q.state == ST_PULSE) && (st_q.pcnt == '0);
    assign flush     = service | pulse_end;
    assign half_rate = half_sel | ~x2_mode;
    assign wdt_reset = (st_q.state == ST_PULSE);

    wdog_seq_det u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (pulse_end),
        .wr_en   (wr_ok),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .service (service)
    );

    wdog_tick_gen u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .run       (run),
        .half_rate (half_rate),
        .tick      (tick)
    );

    wdog_timebase #(
        .PRE_W (PRE_W),
        .WTO_W (WTO_W)
    ) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .run    (run),
        .tick   (tick),
        .wto    (st_q.wto_act),
        .expire (expire)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ok && !wr_sel) begin
            st_d.prog = wr_data[WTO_W-1:0];
        end
        case (st_q.state)
            ST_OFF: begin
                if (service) begin
                    st_d.state   = ST_RUN;
                    st_d.wto_act = st_q.prog;
                end
            end
            ST_RUN: begin
                if (service) begin
                    st_d.wto_act = st_q.prog;
                end else if (expire) begin
                    st_d.state = ST_PULSE;
                    st_d.pcnt  = PCNT_W'(PULSE_LEN - 1);
                end
            end
            ST_PULSE: begin
                if (st_q.pcnt == '0) begin
                    st_d = '0;
                end else begin
                    st_d.pcnt = st_q.pcnt - 1'b1;
                end
            end
            default: st_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
    import wdog_pkg::*;
#(
    parameter int PULSE_LEN = 96
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_sel,
    input logic [7:0] wr_data,
    input wd_state_e  state_q,
    input logic       service,
    input logic       expire,
    input logic       wdt_reset
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hi_cnt <= '0;
        else if (wdt_reset) hi_cnt <= hi_cnt + 1'b1;
        else                hi_cnt <= '0;
    end

    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |=> !wdt_reset);

    // R2
    svc_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        service |=> (state_q == ST_RUN));

    // R3
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && wr_en && wr_sel && wr_data != SEQ_FIRE) |=> (state_q == ST_OFF));

    // R6
    stay_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !expire) |=> (state_q == ST_RUN));

    // R9
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_reset) |-> (hi_cnt == 16'(PULSE_LEN)));

    // R9
    pulse_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset |-> (hi_cnt < 16'(PULSE_LEN)));

    // R10
    after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_reset) |-> (state_q == ST_OFF));

    // R11
    pulse_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE) |-> !service);
endmodule

bind wdog_top wdog_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .state_q   (state_q),
    .service   (service),
    .expire    (expire),
    .wdt_reset (wdt_reset)
);

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
    localparam int PRE_W     = 4;
    localparam int PULSE_LEN = 96;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       half_sel = 1'b0;
    logic       x2_mode = 1'b1;
    logic       wdt_reset;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    wdog_top #(.PRE_W(PRE_W), .WTO_W(3), .PULSE_LEN(PULSE_LEN)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .half_sel  (half_sel),
        .x2_mode   (x2_mode),
        .wdt_reset (wdt_reset)
    );

    always #10 clk = ~clk;

    function automatic int period(input int wto, input bit hs, input bit x2);
        int n;
        n = (1 << PRE_W) * (1 << wto);
        return (hs || !x2) ? 2 * n : n;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge, returns at the negedge after the sampling edge
    task automatic wr(input bit sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic service();
        wr(1'b1, 8'h1E);
        wr(1'b1, 8'hE1);
    endtask

    task automatic measure(output int k);
        k = 0;
        while (k < 10000) begin
            @(negedge clk);
            k++;
            if (wdt_reset) break;
        end
    endtask

    task automatic width(output int w);
        w = 0;
        while (wdt_reset && w < 1000) begin
            @(negedge clk);
            w++;
        end
    endtask

    task automatic quiet(input int n, output int seen);
        seen = 0;
        repeat (n) begin
            @(negedge clk);
            if (wdt_reset) seen++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        int k, w, s, exp, wto;
        bit hs, x2;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and long quiet
        check(wdt_reset == 1'b0, "R1 reset", int'(wdt_reset), 0);
        quiet(5000, s);
        check(s == 0, "R1 off without service", s, 0);

        // R3 lone E1 and broken sequences never enable
        wr(1'b1, 8'hE1);
        wr(1'b1, 8'h1E); wr(1'b1, 8'h55); wr(1'b1, 8'hE1);
        wr(1'b1, 8'h1E); wr(1'b1, 8'h00); wr(1'b1, 8'hE1);
        quiet(300, s);
        check(s == 0, "R3 broken sequence", s, 0);

        // R2 program write between arm and fire; R4 wto=2; R5 undivided tick
        wr(1'b0, 8'h02);
        wr(1'b1, 8'h1E); wr(1'b0, 8'hFA); wr(1'b1, 8'hE1);
        measure(k);
        check(k == period(2, 0, 1), "R2 R4 R5 arm across program write, wto=2", k, period(2, 0, 1));
        width(w);
        check(w == PULSE_LEN, "R9 pulse width", w, PULSE_LEN);

        // R10 program cleared after pulse: fresh service gives wto 0
        quiet(100, s);
        check(s == 0, "R10 off after pulse", s, 0);
        wr(1'b1, 8'h1E); wr(1'b1, 8'h1E); wr(1'b1, 8'hE1);
        measure(k);
        check(k == period(0, 0, 1), "R10 R2 double arm, prog reset", k, period(0, 0, 1));
        width(w);

        // R5 divided tick via half_sel, then via x2_mode=0
        half_sel = 1'b1;
        wr(1'b0, 8'h03); service();
        measure(k);
        check(k == period(3, 1, 1), "R5 half_sel divide", k, period(3, 1, 1));
        width(w);
        half_sel = 1'b0; x2_mode = 1'b0;
        wr(1'b0, 8'h01); service();
        measure(k);
        check(k == period(1, 0, 0), "R5 x2_mode off divide", k, period(1, 0, 0));
        width(w);
        x2_mode = 1'b1;

        // R6 stray writes during run do not stop or restart
        wr(1'b0, 8'h02); service();
        wr(1'b1, 8'h00); wr(1'b1, 8'h1E); wr(1'b1, 8'hFF); wr(1'b1, 8'hE1);
        measure(k);
        check(k + 4 == period(2, 0, 1), "R6 stray writes while running", k + 4, period(2, 0, 1));
        width(w);

        // R7 restart; R8 program write applies only at next service
        wr(1'b0, 8'h01); service();
        wr(1'b0, 8'h03);
        repeat (20) @(negedge clk);
        check(wdt_reset == 1'b0, "R8 no early pulse", int'(wdt_reset), 0);
        service();
        measure(k);
        check(k == period(3, 0, 1), "R7 R8 restart with new period", k, period(3, 0, 1));
        width(w);

        // R8 program write mid-run keeps old period
        wr(1'b0, 8'h01); service();
        wr(1'b0, 8'h07);
        measure(k);
        check(k + 1 == period(1, 0, 1), "R8 old period kept", k + 1, period(1, 0, 1));

        // R11 writes during pulse ignored
        wr(1'b0, 8'h05); wr(1'b1, 8'h1E); wr(1'b1, 8'hE1);
        width(w);
        check(w + 3 == PULSE_LEN, "R11 R9 pulse with writes", w + 3, PULSE_LEN);
        quiet(5000, s);
        check(s == 0, "R11 sequence in pulse ignored", s, 0);
        service();
        measure(k);
        check(k == period(0, 0, 1), "R11 program write in pulse ignored", k, period(0, 0, 1));
        width(w);

        // random runs
        for (int i = 0; i < 20; i++) begin
            wto = int'($urandom % 8);
            hs = 1'($urandom % 2);
            x2 = 1'($urandom % 2);
            half_sel = hs; x2_mode = x2;
            for (int j = 0; j < int'($urandom % 4); j++) begin
                if ($urandom % 2) wr(1'b0, 8'($urandom));
                else begin
                    wr(1'b1, 8'h1E); wr(1'b1, 8'($urandom % 8'h1E));
                end
            end
            wr(1'b0, {5'($urandom), 3'(wto)});
            service();
            measure(k);
            exp = period(wto, hs, x2);
            check(k == exp, "R4 R5 random period", k, exp);
            width(w);
            check(w == PULSE_LEN, "R9 random width", w, PULSE_LEN);
        end

        finish_run();
    end
endmodule